// File: doc/BRIEF.md
# Preload Register Update Unit

This block keeps general registers that were loaded early, ahead of stores whose addresses could not be told apart at compile time, coherent with those later stores. A small pool of address entries records the memory footprint of every such preload: address, access size and the general register it filled. Each later store is compared in the same cycle against every live entry. Where the store writes bytes that the preload read, the store bytes are sent, realigned to the register's layout and with byte enables, to the register file as an update write. Reading the guarded register ends its coherence and returns its entry to the pool.

The pool is smaller than the register file. When a preload finds no free entry, one live entry is taken by a rotating pointer. The register it guarded is marked frozen. A frozen register keeps its own copy of the preload address and size. When it is next read, the block stalls the reader and issues one reload request with that saved address, and it holds the register not ready until the memory side signals completion. Each register shows four status flags: guarded, frozen, ready and trap pending.

Top module: `pru_unit`

## Requirements
- R1: After reset no register is guarded, frozen or trap-pending, every register is ready, and neither an update write nor a reload request is presented.
- R2: A preload marks its destination register guarded and not frozen from the next cycle on. It takes the lowest-numbered free entry. Size code 0 is one byte, 1 is two bytes and 2 is four bytes, and the address is aligned to the size.
- R3: A store that touches bytes read by a live preload in the same 4-byte word raises the update enable of that entry's lane in the cycle after the store, with the entry's register number. Data byte k of the update is the store byte at address preload+k, and byte enable bit k is set exactly for the bytes the store wrote.
- R4: A store to another word, or to bytes of the same word disjoint from a preload, raises no update enable for that entry.
- R5: A read of a guarded register clears its guarded flag and frees its entry, so a later store to that address produces no update.
- R6: At most as many registers as there are entries are guarded at once. A preload with the pool full evicts the entry at a rotating pointer, which starts at entry 0 and advances by one per eviction. The evicted register becomes frozen and unguarded, and the entry then serves the new preload.
- R7: A read of a frozen or not-ready register raises use_stall in the same cycle. The first such read of a frozen, ready register issues a reload request in the next cycle with the register's saved address, size and number, and clears its ready flag. Further reads issue no second request.
- R8: Reload completion for a register sets it ready and clears frozen and trap, after which a read of it no longer stalls.
- R9: When a preload and a store arrive in the same cycle, the store is compared against the entry just written by that preload.
- R10: When a read of a guarded register and a store to its address arrive in the same cycle, the read takes effect first and no update is produced.
- R11: The trap flag of a register follows the trap input of its latest preload.
- R12: A preload to a register that is already guarded reuses the register's old entry and evicts nothing.
- R13: A store that overlaps several live entries raises the update enable of every one of them in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pl_valid | input | 1 | Preload request |
| pl_gr | input | GRW | Preload destination register |
| pl_addr | input | AW | Preload byte address |
| pl_size | input | 2 | Preload size code |
| pl_trap | input | 1 | Preload raised a deferred exception |
| st_valid | input | 1 | Store request |
| st_addr | input | AW | Store byte address |
| st_size | input | 2 | Store size code |
| st_data | input | DW | Store data, right-justified |
| use_valid | input | 1 | Read of a general register |
| use_gr | input | GRW | Register being read |
| use_stall | output | 1 | Read must be held and retried |
| rl_done_valid | input | 1 | Reload completed |
| rl_done_gr | input | GRW | Register whose reload completed |
| rl_req_valid | output | 1 | Reload request |
| rl_req_gr | output | GRW | Register to reload |
| rl_req_addr | output | AW | Saved preload address |
| rl_req_size | output | 2 | Saved preload size |
| upd_en | output | NUM_AR | Update write enable per entry lane |
| upd_gr | output | NUM_AR*GRW | Target register per lane |
| upd_data | output | NUM_AR*DW | Realigned store data per lane |
| upd_be | output | NUM_AR*DW/8 | Byte enables per lane |
| gr_p | output | NUM_GR | Guarded flag per register |
| gr_f | output | NUM_GR | Frozen flag per register |
| gr_r | output | NUM_GR | Ready flag per register |
| gr_t | output | NUM_GR | Trap-pending flag per register |

## Verification
Preload allocation and store comparison can fall in the same cycle, and so can a register read and a store. The bench drives a preload together with a store to the same word and requires an update on the freshly written entry's lane one cycle later. It then drives a read of that register together with another store to the same address, and it requires no update and a cleared guarded flag. Eviction is provoked by filling the pool. The evicted register's stalled read is then judged by the reload request's contents and by the single request it raises.

// File: rtl/pru_pkg.sv
package pru_pkg;
    typedef logic [1:0] psize_t;

    localparam psize_t SZ_BYTE = 2'd0;
    localparam psize_t SZ_HALF = 2'd1;
    localparam psize_t SZ_WORD = 2'd2;

    // bytes covered by an access of the given size, right-justified
    function automatic logic [7:0] size_bytes(input psize_t s);
        logic [7:0] m;
        m = (8'd1 << (4'd1 << s)) - 8'd1;
        return m;
    endfunction
endpackage

// File: rtl/pru_alloc.sv
module pru_alloc #(
    parameter int NUM_AR = 4,
    localparam int ARW = (NUM_AR > 1) ? $clog2(NUM_AR) : 1
) (
    input  logic [NUM_AR-1:0] free_n,
    input  logic [ARW-1:0]    rr_ptr,
    output logic [ARW-1:0]    slot,
    output logic              evict
);
    // lowest free entry wins; with none free the rotating pointer names the victim
    always_comb begin
        slot  = rr_ptr;
        evict = 1'b1;
        for (int i = NUM_AR - 1; i >= 0; i--) begin
            if (!free_n[i]) begin
                slot  = ARW'(i);
                evict = 1'b0;
            end
        end
    end
endmodule

// File: rtl/pru_match.sv
module pru_match
    import pru_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32,
    localparam int NB = DW / 8,
    localparam int OB = $clog2(NB)
) (
    input  logic          ent_v,
    input  logic [AW-1:0] ent_addr,
    input  psize_t        ent_size,
    input  logic          st_valid,
    input  logic [AW-1:0] st_addr,
    input  psize_t        st_size,
    input  logic [DW-1:0] st_data,
    output logic          hit,
    output logic [DW-1:0] data,
    output logic [NB-1:0] be
);
    logic [NB-1:0] ld_lanes;
    logic [NB-1:0] st_lanes;
    logic [DW-1:0] st_word;
    logic          same_word;

    always_comb begin
        ld_lanes  = NB'(size_bytes(ent_size)) << ent_addr[OB-1:0];
        st_lanes  = NB'(size_bytes(st_size)) << st_addr[OB-1:0];
        same_word = (ent_addr[AW-1:OB] == st_addr[AW-1:OB]);
        hit       = st_valid & ent_v & same_word & (|(ld_lanes & st_lanes));
        st_word   = st_data << (8 * st_addr[OB-1:0]);
        data      = st_word >> (8 * ent_addr[OB-1:0]);
        be        = (st_lanes >> ent_addr[OB-1:0]) & NB'(size_bytes(ent_size));
    end
endmodule

// File: rtl/pru_unit.sv
module pru_unit
    import pru_pkg::*;
#(
    parameter int NUM_GR = 8,
    parameter int NUM_AR = 4,
    parameter int AW     = 16,
    parameter int DW     = 32,
    localparam int GRW = (NUM_GR > 1) ? $clog2(NUM_GR) : 1,
    localparam int ARW = (NUM_AR > 1) ? $clog2(NUM_AR) : 1,
    localparam int NB  = DW / 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pl_valid,
    input  logic [GRW-1:0]        pl_gr,
    input  logic [AW-1:0]         pl_addr,
    input  logic [1:0]            pl_size,
    input  logic                  pl_trap,
    input  logic                  st_valid,
    input  logic [AW-1:0]         st_addr,
    input  logic [1:0]            st_size,
    input  logic [DW-1:0]         st_data,
    input  logic                  use_valid,
    input  logic [GRW-1:0]        use_gr,
    output logic                  use_stall,
    input  logic                  rl_done_valid,
    input  logic [GRW-1:0]        rl_done_gr,
    output logic                  rl_req_valid,
    output logic [GRW-1:0]        rl_req_gr,
    output logic [AW-1:0]         rl_req_addr,
    output logic [1:0]            rl_req_size,
    output logic [NUM_AR-1:0]     upd_en,
    output logic [NUM_AR*GRW-1:0] upd_gr,
    output logic [NUM_AR*DW-1:0]  upd_data,
    output logic [NUM_AR*NB-1:0]  upd_be,
    output logic [NUM_GR-1:0]     gr_p,
    output logic [NUM_GR-1:0]     gr_f,
    output logic [NUM_GR-1:0]     gr_r,
    output logic [NUM_GR-1:0]     gr_t
);
    typedef struct packed {
        logic           v;
        logic [AW-1:0]  addr;
        psize_t         size;
        logic [GRW-1:0] gr;
    } ent_t;

    typedef struct packed {
        logic           p;
        logic           f;
        logic           r;
        logic           t;
        logic [AW-1:0]  addr;
        psize_t         size;
        logic [ARW-1:0] link;
    } greg_t;

    typedef struct packed {
        ent_t  [NUM_AR-1:0]           ar;
        greg_t [NUM_GR-1:0]           gr;
        logic  [ARW-1:0]              rr;
        logic                         rl_v;
        logic  [GRW-1:0]              rl_gr;
        logic  [AW-1:0]               rl_addr;
        psize_t                       rl_size;
        logic  [NUM_AR-1:0]           up_en;
        logic  [NUM_AR-1:0][GRW-1:0]  up_gr;
        logic  [NUM_AR-1:0][DW-1:0]   up_data;
        logic  [NUM_AR-1:0][NB-1:0]   up_be;
    } state_t;

    state_t q, d;

    greg_t                 use_g, pl_g;
    logic                  use_rel;
    logic [NUM_AR-1:0]     v_mid;
    logic [ARW-1:0]        slot;
    logic                  evict;
    ent_t [NUM_AR-1:0]     ar_post;
    logic [NUM_AR-1:0]     hit;
    logic [NUM_AR-1:0][DW-1:0] m_data;
    logic [NUM_AR-1:0][NB-1:0] m_be;

    // stage 1: entries still live after reads and preload self-release
    always_comb begin
        use_g   = q.gr[use_gr];
        pl_g    = q.gr[pl_gr];
        use_rel = use_valid & use_g.p & ~use_g.f & use_g.r;
        for (int i = 0; i < NUM_AR; i++) begin
            v_mid[i] = q.ar[i].v
                     & ~(use_rel && (use_g.link == ARW'(i)))
                     & ~(pl_valid && pl_g.p && (pl_g.link == ARW'(i)));
        end
    end

    pru_alloc #(.NUM_AR(NUM_AR)) u_alloc (
        .free_n (v_mid),
        .rr_ptr (q.rr),
        .slot   (slot),
        .evict  (evict)
    );

    // stage 2: table as the store sees it, preload already placed
    always_comb begin
        for (int i = 0; i < NUM_AR; i++) begin
            ar_post[i]   = q.ar[i];
            ar_post[i].v = v_mid[i];
            if (pl_valid && (slot == ARW'(i))) begin
                ar_post[i].v    = 1'b1;
                ar_post[i].addr = pl_addr;
                ar_post[i].size = pl_size;
                ar_post[i].gr   = pl_gr;
            end
        end
    end

    for (genvar g = 0; g < NUM_AR; g++) begin : g_cmp
        pru_match #(.AW(AW), .DW(DW)) u_match (
            .ent_v    (ar_post[g].v),
            .ent_addr (ar_post[g].addr),
            .ent_size (ar_post[g].size),
            .st_valid (st_valid),
            .st_addr  (st_addr),
            .st_size  (st_size),
            .st_data  (st_data),
            .hit      (hit[g]),
            .data     (m_data[g]),
            .be       (m_be[g])
        );
    end

    // next-state computation
    always_comb begin
        logic [GRW-1:0] victim;
        d       = q;
        d.ar    = ar_post;
        d.rl_v  = 1'b0;
        d.up_en = hit;
        victim  = q.ar[slot].gr;
        for (int i = 0; i < NUM_AR; i++) begin
            d.up_gr[i]   = ar_post[i].gr;
            d.up_data[i] = m_data[i];
            d.up_be[i]   = m_be[i];
        end

        if (rl_done_valid) begin
            d.gr[rl_done_gr].r = 1'b1;
            d.gr[rl_done_gr].f = 1'b0;
            d.gr[rl_done_gr].t = 1'b0;
        end

        if (use_rel) begin
            d.gr[use_gr].p = 1'b0;
        end else if (use_valid && use_g.f && use_g.r) begin
            d.rl_v          = 1'b1;
            d.rl_gr         = use_gr;
            d.rl_addr       = use_g.addr;
            d.rl_size       = use_g.size;
            d.gr[use_gr].r  = 1'b0;
        end

        if (pl_valid) begin
            if (evict) begin
                d.gr[victim].p = 1'b0;
                d.gr[victim].f = 1'b1;
                d.rr = (q.rr == ARW'(NUM_AR - 1)) ? '0 : q.rr + 1'b1;
            end
            d.gr[pl_gr].p    = 1'b1;
            d.gr[pl_gr].f    = 1'b0;
            d.gr[pl_gr].r    = 1'b1;
            d.gr[pl_gr].t    = pl_trap;
            d.gr[pl_gr].addr = pl_addr;
            d.gr[pl_gr].size = pl_size;
            d.gr[pl_gr].link = slot;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
            for (int i = 0; i < NUM_GR; i++) begin
                q.gr[i].r <= 1'b1;
            end
        end else begin
            q <= d;
        end
    end

    assign use_stall    = use_valid & (use_g.f | ~use_g.r);
    assign rl_req_valid = q.rl_v;
    assign rl_req_gr    = q.rl_gr;
    assign rl_req_addr  = q.rl_addr;
    assign rl_req_size  = q.rl_size;
    assign upd_en       = q.up_en;
    assign upd_gr       = q.up_gr;
    assign upd_data     = q.up_data;
    assign upd_be       = q.up_be;

    always_comb begin
        for (int i = 0; i < NUM_GR; i++) begin
            gr_p[i] = q.gr[i].p;
            gr_f[i] = q.gr[i].f;
            gr_r[i] = q.gr[i].r;
            gr_t[i] = q.gr[i].t;
        end
    end
endmodule

// File: rtl/pru_checker.sv
module pru_checker #(
    parameter int NUM_GR = 8,
    parameter int NUM_AR = 4,
    localparam int GRW = (NUM_GR > 1) ? $clog2(NUM_GR) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pl_valid,
    input logic [GRW-1:0]    pl_gr,
    input logic              st_valid,
    input logic              use_valid,
    input logic [GRW-1:0]    use_gr,
    input logic              use_stall,
    input logic              rl_done_valid,
    input logic [GRW-1:0]    rl_done_gr,
    input logic              rl_req_valid,
    input logic [GRW-1:0]    rl_req_gr,
    input logic [NUM_AR-1:0] upd_en,
    input logic [NUM_GR-1:0] gr_p,
    input logic [NUM_GR-1:0] gr_f,
    input logic [NUM_GR-1:0] gr_r
);
    AST_PRELOAD_GUARDS: assert property (@(posedge clk) disable iff (!rst_n)
        pl_valid |=> gr_p[$past(pl_gr)]); // R2

    AST_UPD_FROM_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (|upd_en) |-> $past(st_valid)); // R3

    AST_GUARD_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(gr_p) <= NUM_AR); // R6

    AST_GUARD_FROZEN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (gr_p & gr_f) == '0); // R6

    AST_STALL_ON_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (use_valid && (gr_f[use_gr] || !gr_r[use_gr])) |-> use_stall); // R7

    AST_RELOAD_FROM_USE: assert property (@(posedge clk) disable iff (!rst_n)
        rl_req_valid |-> $past(use_valid && gr_f[use_gr] && gr_r[use_gr])); // R7

    AST_RELOAD_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rl_req_valid |-> !gr_r[rl_req_gr]); // R7

    AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rl_done_valid |=> gr_r[$past(rl_done_gr)]); // R8
endmodule

bind pru_unit pru_checker #(.NUM_GR(NUM_GR), .NUM_AR(NUM_AR)) u_chk (.*);

// File: tb/sim_pru_unit.sv
module sim_pru_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_GR = 8;
    localparam int NUM_AR = 4;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int GRW = 3;
    localparam int NB = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pl_valid = 0, pl_trap = 0, st_valid = 0, use_valid = 0, rl_done_valid = 0;
    logic [GRW-1:0] pl_gr = 0, use_gr = 0, rl_done_gr = 0;
    logic [AW-1:0] pl_addr = 0, st_addr = 0;
    logic [1:0] pl_size = 0, st_size = 0;
    logic [DW-1:0] st_data = 0;
    logic use_stall, rl_req_valid;
    logic [GRW-1:0] rl_req_gr;
    logic [AW-1:0] rl_req_addr;
    logic [1:0] rl_req_size;
    logic [NUM_AR-1:0] upd_en;
    logic [NUM_AR*GRW-1:0] upd_gr;
    logic [NUM_AR*DW-1:0] upd_data;
    logic [NUM_AR*NB-1:0] upd_be;
    logic [NUM_GR-1:0] gr_p, gr_f, gr_r, gr_t;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pru_unit #(.NUM_GR(NUM_GR), .NUM_AR(NUM_AR), .AW(AW), .DW(DW)) u0 (.*);

    typedef struct packed {
        logic [15:0] pa;
        logic [1:0]  ps;
        logic [15:0] sa;
        logic [1:0]  ss;
        logic [31:0] sd;
        logic        en;
        logic [3:0]  be;
        logic [31:0] ed;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{16'h0100, 2'd2, 16'h0100, 2'd2, 32'hAABBCCDD, 1'b1, 4'b1111, 32'hAABBCCDD},
        '{16'h0100, 2'd2, 16'h0102, 2'd0, 32'h0000005A, 1'b1, 4'b0100, 32'h005A0000},
        '{16'h0102, 2'd1, 16'h0100, 2'd2, 32'h11223344, 1'b1, 4'b0011, 32'h00001122},
        '{16'h0103, 2'd0, 16'h0102, 2'd1, 32'h0000BEEF, 1'b1, 4'b0001, 32'h000000BE},
        '{16'h0101, 2'd0, 16'h0100, 2'd2, 32'h11223344, 1'b1, 4'b0001, 32'h00000033},
        '{16'h0100, 2'd1, 16'h0102, 2'd1, 32'h00001234, 1'b0, 4'b0000, 32'h00000000},
        '{16'h0100, 2'd2, 16'h0104, 2'd2, 32'h00005678, 1'b0, 4'b0000, 32'h00000000}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] lane_mask(input logic [3:0] be);
        logic [31:0] m;
        for (int b = 0; b < 4; b++) m[8*b +: 8] = {8{be[b]}};
        return m;
    endfunction

    task automatic step();
        @(negedge clk);
    endtask

    task automatic preload(input logic [GRW-1:0] g, input logic [AW-1:0] a,
                           input logic [1:0] s, input logic trap);
        pl_valid = 1; pl_gr = g; pl_addr = a; pl_size = s; pl_trap = trap;
        step();
        pl_valid = 0; pl_trap = 0;
    endtask

    task automatic store(input logic [AW-1:0] a, input logic [1:0] s, input logic [DW-1:0] dt);
        st_valid = 1; st_addr = a; st_size = s; st_data = dt;
        step();
        st_valid = 0;
    endtask

    task automatic use_reg(input logic [GRW-1:0] g);
        use_valid = 1; use_gr = g;
        step();
        use_valid = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1;
        step();
        chk("R1 guarded", 64'(gr_p), 64'h0);
        chk("R1 frozen", 64'(gr_f), 64'h0);
        chk("R1 ready", 64'(gr_r), 64'hFF);
        chk("R1 trap", 64'(gr_t), 64'h0);
        chk("R1 update", 64'(upd_en), 64'h0);
        chk("R1 reload", 64'(rl_req_valid), 64'h0);

        // table of forwarding cases, entry 0 each time
        for (int k = 0; k < 7; k++) begin
            preload(3'd0, VECS[k].pa, VECS[k].ps, 1'b0);
            chk("R2 guarded after preload", 64'(gr_p[0]), 64'h1);
            store(VECS[k].sa, VECS[k].ss, VECS[k].sd);
            if (VECS[k].en) begin
                chk("R3 lane0 enable", 64'(upd_en), 64'h1);
                chk("R3 lane0 register", 64'(upd_gr[GRW-1:0]), 64'h0);
                chk("R3 lane0 byte enables", 64'(upd_be[3:0]), 64'(VECS[k].be));
                chk("R3 lane0 data", 64'(upd_data[31:0] & lane_mask(VECS[k].be)),
                    64'(VECS[k].ed));
            end else begin
                chk("R4 no overlap", 64'(upd_en), 64'h0);
            end
            use_reg(3'd0);
            chk("R5 read ends guard", 64'(gr_p[0]), 64'h0);
        end

        // R5: freed entry no longer tracks its address
        preload(3'd6, 16'h0700, 2'd2, 1'b0);
        use_reg(3'd6);
        store(16'h0700, 2'd2, 32'h01020304);
        chk("R5 store after release", 64'(upd_en), 64'h0);

        // R9: preload and store in one cycle
        pl_valid = 1; pl_gr = 3'd1; pl_addr = 16'h0200; pl_size = 2'd2;
        st_valid = 1; st_addr = 16'h0200; st_size = 2'd2; st_data = 32'hCAFEF00D;
        step();
        pl_valid = 0; st_valid = 0;
        chk("R9 enable", 64'(upd_en), 64'h1);
        chk("R9 register", 64'(upd_gr[GRW-1:0]), 64'h1);
        chk("R9 data", 64'(upd_data[31:0]), 64'hCAFEF00D);
        chk("R9 guarded", 64'(gr_p[1]), 64'h1);

        // R10: read and store in one cycle
        use_valid = 1; use_gr = 3'd1;
        st_valid = 1; st_addr = 16'h0200; st_size = 2'd2; st_data = 32'h0BADBEEF;
        step();
        use_valid = 0; st_valid = 0;
        chk("R10 no update", 64'(upd_en), 64'h0);
        chk("R10 guard cleared", 64'(gr_p[1]), 64'h0);

        // R13: one store, two entries
        preload(3'd2, 16'h0300, 2'd2, 1'b0);
        preload(3'd3, 16'h0302, 2'd1, 1'b0);
        store(16'h0303, 2'd0, 32'h00000077);
        chk("R13 both lanes", 64'(upd_en), 64'h3);
        chk("R13 lane0 be", 64'(upd_be[3:0]), 64'h8);
        chk("R13 lane0 data", 64'(upd_data[31:0] & 32'hFF000000), 64'h77000000);
        chk("R13 lane1 register", 64'(upd_gr[2*GRW-1:GRW]), 64'h3);
        chk("R13 lane1 be", 64'(upd_be[7:4]), 64'h2);
        chk("R13 lane1 data", 64'(upd_data[63:32] & 32'h0000FF00), 64'h00007700);

        // R12: re-preload of a guarded register
        preload(3'd2, 16'h0400, 2'd2, 1'b0);
        chk("R12 guarded set", 64'(gr_p), 64'h0C);
        chk("R12 no freeze", 64'(gr_f), 64'h0);
        store(16'h0400, 2'd2, 32'h12345678);
        chk("R12 reused lane", 64'(upd_en), 64'h1);
        chk("R12 reused register", 64'(upd_gr[GRW-1:0]), 64'h2);
        use_reg(3'd2);
        use_reg(3'd3);
        chk("R5 all released", 64'(gr_p), 64'h0);

        // R6 / R11: fill the pool, then evict
        preload(3'd0, 16'h0010, 2'd2, 1'b0);
        preload(3'd1, 16'h0020, 2'd2, 1'b1);
        preload(3'd2, 16'h0030, 2'd2, 1'b0);
        preload(3'd3, 16'h0040, 2'd2, 1'b0);
        chk("R6 pool full", 64'(gr_p), 64'h0F);
        chk("R11 trap follows preload", 64'(gr_t), 64'h02);
        preload(3'd4, 16'h0050, 2'd2, 1'b0);
        chk("R6 first eviction frozen", 64'(gr_f), 64'h01);
        chk("R6 first eviction guarded", 64'(gr_p), 64'h1E);
        preload(3'd5, 16'h0060, 2'd2, 1'b0);
        chk("R6 second eviction frozen", 64'(gr_f), 64'h03);
        chk("R6 second eviction guarded", 64'(gr_p), 64'h3C);
        store(16'h0010, 2'd2, 32'hDEADDEAD);
        chk("R6 evicted address untracked", 64'(upd_en), 64'h0);
        store(16'h0050, 2'd2, 32'h55AA55AA);
        chk("R6 entry serves new preload", 64'(upd_en), 64'h1);
        chk("R6 entry new register", 64'(upd_gr[GRW-1:0]), 64'h4);

        // R7 / R8: read of a frozen register
        use_valid = 1; use_gr = 3'd0;
        #1;
        chk("R7 stall on frozen", 64'(use_stall), 64'h1);
        step();
        chk("R7 reload issued", 64'(rl_req_valid), 64'h1);
        chk("R7 reload address", 64'(rl_req_addr), 64'h0010);
        chk("R7 reload register", 64'(rl_req_gr), 64'h0);
        chk("R7 reload size", 64'(rl_req_size), 64'h2);
        chk("R7 not ready", 64'(gr_r[0]), 64'h0);
        #1;
        chk("R7 stall while pending", 64'(use_stall), 64'h1);
        step();
        chk("R7 single request", 64'(rl_req_valid), 64'h0);
        use_valid = 0;
        rl_done_valid = 1; rl_done_gr = 3'd0;
        step();
        rl_done_valid = 0;
        chk("R8 ready again", 64'(gr_r[0]), 64'h1);
        chk("R8 unfrozen", 64'(gr_f[0]), 64'h0);
        use_valid = 1; use_gr = 3'd0;
        #1;
        chk("R8 no stall", 64'(use_stall), 64'h0);
        step();
        use_valid = 0;
        chk("R8 no further reload", 64'(rl_req_valid), 64'h0);

        // R11: completion clears trap
        use_reg(3'd1);
        chk("R7 reload for trapped", 64'(rl_req_gr), 64'h1);
        rl_done_valid = 1; rl_done_gr = 3'd1;
        step();
        rl_done_valid = 0;
        chk("R11 trap cleared", 64'(gr_t[1]), 64'h0);
        chk("R8 none frozen", 64'(gr_f), 64'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule